// File: doc/BRIEF.md
# CAN Bit-Timing Parameter Search Engine

This block works out the bit-timing setup of a CAN controller from two numbers: the frequency of the clock that feeds the controller and the bit rate wanted on the bus. After a start pulse it steps through every allowed quanta-per-bit count, from the largest down to the smallest. For each count it forms a rounded and clamped prescaler, works out the bit rate that this pair would give, and keeps the pair whose rate is closest to the target. It then splits the chosen count into a fixed sync quantum, a propagation segment, phase segment 1 and phase segment 2, and packs these with the prescaler, a jump-width code and a clock-source flag into one 32-bit setup word.

The controller clock can be either the peripheral bus clock or the external crystal clock, and an input selects which one is used. A bypass input skips the search entirely, and the rate operand is then returned as a ready-made setup word. One shared multi-cycle divider does all the divisions, so a search takes a few thousand cycles. The block reports the end of the work with a single-cycle done pulse and holds the result until the next operation finishes.

Top module: `can_btcalc`

## Requirements
- R1: When `bypass` is high as a start is accepted, `word` equals `rate` bit for bit in the very next cycle, `done` pulses in that same cycle, and `busy` never rises.
- R2: When `src_bus` is 1 the search uses `bus_hz`, and when it is 0 it uses `xtal_hz`. Bit 13 of `word` is 1 exactly when the bus clock was used.
- R3: Counts from 25 down to 8 are tried. For each count n, base = f/n and prescaler = (base + rate/2)/rate, clamped to at most 256 and forced up to 1 if it comes out as 0. The achieved rate is base/prescaler.
- R4: A count replaces the best so far only when its absolute rate error is strictly smaller, so on a tie the larger count wins.
- R5: Phase segment 2 is 8 quanta for n ≥ 18, 7 for n ≥ 16, 6 for n ≥ 14, 5 for n ≥ 12, 4 for n ≥ 10, and 3 otherwise. Time segment 1 is n − phase segment 2 − 1.
- R6: When time segment 1 is odd, the propagation segment is one quantum longer than phase segment 1. When it is even, the two are equal.
- R7: The word fields hold each length minus one: bits 31:24 hold the prescaler, bits 23:22 hold the jump width (code 01), bits 21:19 hold phase segment 1, bits 18:16 hold phase segment 2, and bits 2:0 hold propagation. All other bits are zero.
- R8: `done` is high for exactly one cycle per operation, `busy` is high while a search runs, and `word` changes only in the cycle where `done` is high.
- R9: A start that arrives while `busy` is high is ignored, and the search already running finishes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| bypass | input | 1 | Return `rate` as the word with no search |
| src_bus | input | 1 | 1 selects the bus clock, 0 selects the crystal clock |
| bus_hz | input | 32 | Bus clock frequency in Hz |
| xtal_hz | input | 32 | Crystal clock frequency in Hz |
| rate | input | 32 | Target bit rate in bit/s, or the ready-made word in bypass |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| word | output | 32 | Packed setup word |

## Verification
A wrong best-candidate register or count register shows up only at the final `done`. There it appears as a wrong prescaler or wrong segment fields, and the segment fields may no longer add up to a legal count or follow the phase-2 band. The bench therefore compares each completed word with a value it computes itself, using hand-worked cases for exact hits, ties, clamping and the forced-to-1 prescaler. A fault in the handshake or hold logic is visible within one cycle: a second `done`, a word that changes outside `done`, or a start taken while busy.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_PRE,
    ST_ACH,
    ST_PACK
  } bt_state_t;

  localparam int PRESC_LSB = 24;
  localparam int SJW_LSB   = 22;
  localparam int PS1_LSB   = 19;
  localparam int PS2_LSB   = 16;
  localparam int SRC_BIT   = 13;
  localparam int PROP_LSB  = 0;

  // phase segment 2 length from the quanta count band
  function automatic logic [3:0] ps2_len(input logic [4:0] nq);
    if (nq >= 5'd18)      return 4'd8;
    else if (nq >= 5'd16) return 4'd7;
    else if (nq >= 5'd14) return 4'd6;
    else if (nq >= 5'd12) return 4'd5;
    else if (nq >= 5'd10) return 4'd4;
    else                  return 4'd3;
  endfunction

endpackage

// File: rtl/can_bt_div.sv
module can_bt_div #(
  parameter int DW = 33,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dvd,
  input  logic [VW-1:0] dvs,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW + 1);

  logic [VW:0]   rem;
  logic [VW-1:0] dvs_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [VW:0]   rem_sh;

  assign rem_sh = {rem[VW-1:0], quo[DW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dvs_r <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
      quo   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quo   <= dvd;
        dvs_r <= dvs;
        rem   <= '0;
        cnt   <= CW'(DW);
        run   <= 1'b1;
      end else if (run) begin
        if (rem_sh >= {1'b0, dvs_r}) begin
          rem <= rem_sh - {1'b0, dvs_r};
          quo <= {quo[DW-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          quo <= {quo[DW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_bt_pack.sv
module can_bt_pack #(
  parameter int NW = 5,
  parameter int PW = 9
) (
  input  logic [NW-1:0] nq,
  input  logic [PW-1:0] presc,
  input  logic          src,
  output logic [31:0]   word
);
  import can_bt_pkg::*;

  logic [3:0] p2;
  logic [4:0] ts1;
  logic [4:0] half;
  logic [2:0] prop_f;
  logic [2:0] ps1_f;
  logic [2:0] ps2_f;
  logic [7:0] pre_f;

  always_comb begin
    p2    = ps2_len(5'(nq));
    ts1   = 5'(nq) - 5'(p2) - 5'd1;
    half  = ts1 >> 1;
    ps2_f = 3'(p2 - 4'd1);
    if (ts1[0]) begin
      prop_f = 3'(half);
      ps1_f  = 3'(half - 5'd1);
    end else begin
      prop_f = 3'(half - 5'd1);
      ps1_f  = 3'(half - 5'd1);
    end
    pre_f = 8'(presc - 1'b1);
    word  = '0;
    word[PRESC_LSB +: 8] = pre_f;
    word[SJW_LSB +: 2]   = 2'b01;
    word[PS1_LSB +: 3]   = ps1_f;
    word[PS2_LSB +: 3]   = ps2_f;
    word[SRC_BIT]        = src;
    word[PROP_LSB +: 3]  = prop_f;
  end
endmodule

// File: rtl/can_btcalc.sv
module can_btcalc #(
  parameter int W    = 32,
  parameter int QMAX = 25,
  parameter int QMIN = 8,
  parameter int PMAX = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bypass,
  input  logic         src_bus,
  input  logic [W-1:0] bus_hz,
  input  logic [W-1:0] xtal_hz,
  input  logic [W-1:0] rate,
  output logic         busy,
  output logic         done,
  output logic [31:0]  word
);
  import can_bt_pkg::*;

  localparam int NW = $clog2(QMAX + 1);
  localparam int PW = $clog2(PMAX + 1);
  localparam int DW = W + 1;

  bt_state_t     st;
  logic          go;
  logic [W-1:0]  clk_r;
  logic [W-1:0]  tgt_r;
  logic          src_r;
  logic [NW-1:0] n_r;
  logic [W-1:0]  base_r;
  logic [PW-1:0] presc_r;
  logic [NW-1:0] best_n;
  logic [PW-1:0] best_p;
  logic [W:0]    best_err;

  logic [DW-1:0] dvd;
  logic [W-1:0]  dvs;
  logic          dv_fin;
  logic [DW-1:0] quo;
  logic [PW-1:0] presc_c;
  logic [W-1:0]  ach;
  logic [W-1:0]  err;
  logic [31:0]   packed_w;

  always_comb begin
    dvd = '0;
    dvs = '0;
    case (st)
      ST_BASE: begin
        dvd = {1'b0, clk_r};
        dvs = W'(n_r);
      end
      ST_PRE: begin
        dvd = {1'b0, base_r} + {2'b00, tgt_r[W-1:1]};
        dvs = tgt_r;
      end
      ST_ACH: begin
        dvd = {1'b0, base_r};
        dvs = W'(presc_r);
      end
      default: ;
    endcase
  end

  can_bt_div #(.DW(DW), .VW(W)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .dvd (dvd),
    .dvs (dvs),
    .fin (dv_fin),
    .quo (quo)
  );

  always_comb begin
    if (quo == '0)                presc_c = PW'(1);
    else if (quo > DW'(PMAX))     presc_c = PW'(PMAX);
    else                          presc_c = quo[PW-1:0];
    ach = quo[W-1:0];
    err = (ach >= tgt_r) ? (ach - tgt_r) : (tgt_r - ach);
  end

  can_bt_pack #(.NW(NW), .PW(PW)) u_pack (
    .nq    (best_n),
    .presc (best_p),
    .src   (src_r),
    .word  (packed_w)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      go       <= 1'b0;
      clk_r    <= '0;
      tgt_r    <= '0;
      src_r    <= 1'b0;
      n_r      <= '0;
      base_r   <= '0;
      presc_r  <= '0;
      best_n   <= '0;
      best_p   <= '0;
      best_err <= '0;
      done     <= 1'b0;
      word     <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (bypass) begin
              word <= 32'(rate);
              done <= 1'b1;
            end else begin
              clk_r    <= src_bus ? bus_hz : xtal_hz;
              tgt_r    <= rate;
              src_r    <= src_bus;
              n_r      <= NW'(QMAX);
              best_err <= {1'b1, {W{1'b0}}};
              best_n   <= NW'(QMAX);
              best_p   <= PW'(1);
              st       <= ST_BASE;
              go       <= 1'b1;
            end
          end
        end
        ST_BASE: if (dv_fin) begin
          base_r <= quo[W-1:0];
          st     <= ST_PRE;
          go     <= 1'b1;
        end
        ST_PRE: if (dv_fin) begin
          presc_r <= presc_c;
          st      <= ST_ACH;
          go      <= 1'b1;
        end
        ST_ACH: if (dv_fin) begin
          if ({1'b0, err} < best_err) begin
            best_err <= {1'b0, err};
            best_n   <= n_r;
            best_p   <= presc_r;
          end
          if (n_r == NW'(QMIN)) begin
            st <= ST_PACK;
          end else begin
            n_r <= n_r - 1'b1;
            st  <= ST_BASE;
            go  <= 1'b1;
          end
        end
        ST_PACK: begin
          word <= packed_w;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/can_btcalc_chk.sv
module can_btcalc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         bypass,
  input logic [W-1:0] rate,
  input logic         busy,
  input logic         done,
  input logic [31:0]  word
);
  logic       byp_m;
  logic [4:0] tot;
  logic [3:0] p2_exp;

  always_ff @(posedge clk) begin
    if (rst)                  byp_m <= 1'b0;
    else if (start && !busy)  byp_m <= bypass;
  end

  always_comb begin
    tot = 5'd4 + 5'(word[2:0]) + 5'(word[21:19]) + 5'(word[18:16]);
    if (tot >= 5'd18)      p2_exp = 4'd8;
    else if (tot >= 5'd16) p2_exp = 4'd7;
    else if (tot >= 5'd14) p2_exp = 4'd6;
    else if (tot >= 5'd12) p2_exp = 4'd5;
    else if (tot >= 5'd10) p2_exp = 4'd4;
    else                   p2_exp = 4'd3;
  end

  p_bypass_echo_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && bypass) |=> (done && word == 32'($past(rate))));

  p_sjw_code_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !byp_m) |-> (word[23:22] == 2'b01 && word[15:14] == 2'b00 && word[12:3] == '0));

  p_ps2_band_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !byp_m) |-> (tot >= 5'd8 && tot <= 5'd25 && (4'(word[18:16]) + 4'd1) == p2_exp));

  p_split_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !byp_m) |-> (word[2:0] == word[21:19] || word[2:0] == word[21:19] + 3'd1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(word) |-> done);

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind can_btcalc can_btcalc_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .bypass (bypass),
  .rate   (rate),
  .busy   (busy),
  .done   (done),
  .word   (word)
);

// File: tb/can_btcalc_bench.sv
module can_btcalc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bypass = 1'b0;
  logic        src_bus = 1'b0;
  logic [31:0] bus_hz = '0;
  logic [31:0] xtal_hz = '0;
  logic [31:0] rate = '0;
  logic        busy;
  logic        done;
  logic [31:0] word;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  can_btcalc u_can_btcalc (
    .clk(clk), .rst(rst), .start(start), .bypass(bypass), .src_bus(src_bus),
    .bus_hz(bus_hz), .xtal_hz(xtal_hz), .rate(rate),
    .busy(busy), .done(done), .word(word)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference built from R3..R7
  function automatic logic [31:0] ref_word(input longint f, input longint tgt, input bit src);
    longint best_e = 64'h7FFF_FFFF_FFFF_FFFF;
    int bn = 25;
    longint bp = 1;
    int p2, t1, pr, p1;
    logic [31:0] w;
    for (int n = 25; n >= 8; n--) begin
      longint b = f / n;
      longint p = (b + tgt / 2) / tgt;
      longint a, e;
      if (p == 0) p = 1;
      if (p > 256) p = 256;
      a = b / p;
      e = (a > tgt) ? a - tgt : tgt - a;
      if (e < best_e) begin best_e = e; bn = n; bp = p; end
    end
    p2 = (bn >= 18) ? 8 : (bn >= 16) ? 7 : (bn >= 14) ? 6 : (bn >= 12) ? 5 : (bn >= 10) ? 4 : 3;
    t1 = bn - p2 - 1;
    p1 = t1 / 2;
    pr = t1 - p1;
    w = '0;
    w[31:24] = 8'(bp - 1);
    w[23:22] = 2'b01;
    w[21:19] = 3'(p1 - 1);
    w[18:16] = 3'(p2 - 1);
    w[13]    = src;
    w[2:0]   = 3'(pr - 1);
    return w;
  endfunction

  // starts one operation; returns the word and the number of negedges until done
  task automatic run(input bit byp, input bit src, input logic [31:0] b, input logic [31:0] x,
                     input logic [31:0] r, output logic [31:0] w, output int lat, output int busy_seen);
    @(negedge clk);
    bypass = byp; src_bus = src; bus_hz = b; xtal_hz = x; rate = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy_seen = 0;
    while (!done && lat < 5000) begin
      if (busy) busy_seen = 1;
      @(negedge clk);
      lat++;
    end
    w = word;
  endtask

  task automatic t_reset();
    chk("R8 reset done", 32'(done), 32'd0);
    chk("R8 reset busy", 32'(busy), 32'd0);
    chk("R7 reset word", word, 32'd0);
  endtask

  task automatic t_bypass();
    logic [31:0] w; int lat, bs;
    run(1'b1, 1'b0, 32'd48_000_000, 32'd8_000_000, 32'hDEAD_BEEF, w, lat, bs);
    chk("R1 bypass word", w, 32'hDEAD_BEEF);
    chk("R1 bypass latency", 32'(lat), 32'd1);
    chk("R1 bypass no busy", 32'(bs), 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_src();
    logic [31:0] w; int lat, bs;
    run(1'b0, 1'b1, 32'd48_000_000, 32'd8_000_000, 32'd500_000, w, lat, bs);
    chk("R2 bus source word", w, ref_word(48_000_000, 500_000, 1'b1));
    chk("R2 bus flag bit13", 32'(w[13]), 32'd1);
    chk("R8 busy during search", 32'(bs), 32'd1);
    run(1'b0, 1'b0, 32'd48_000_000, 32'd8_000_000, 32'd500_000, w, lat, bs);
    chk("R2 crystal source word", w, ref_word(8_000_000, 500_000, 1'b0));
    chk("R2 crystal flag bit13", 32'(w[13]), 32'd0);
  endtask

  task automatic t_exact();
    logic [31:0] w; int lat, bs;
    // 24 MHz / 1 Mbit: n=24, presc 1, ts1=15 odd -> prop 8, ps1 7, ps2 8
    run(1'b0, 1'b0, 32'd0, 32'd24_000_000, 32'd1_000_000, w, lat, bs);
    chk("R6 R7 exact hit n=24", w, 32'h0077_0007);
  endtask

  task automatic t_tie();
    logic [31:0] w; int lat, bs;
    // 20 MHz / 100 kbit: n=25 presc 8 and n=20 presc 10 are both exact
    run(1'b0, 1'b0, 32'd0, 32'd20_000_000, 32'd100_000, w, lat, bs);
    chk("R4 tie keeps n=25", w, 32'h077F_0007);
  endtask

  task automatic t_clamp();
    logic [31:0] w; int lat, bs;
    // 50 MHz / 1 kbit: prescaler clamped to 256, n=25 closest
    run(1'b0, 1'b1, 32'd50_000_000, 32'd0, 32'd1_000, w, lat, bs);
    chk("R3 prescaler clamp 256", w, 32'hFF7F_2007);
  endtask

  task automatic t_zero_presc();
    logic [31:0] w; int lat, bs;
    // 8 MHz / 4 Mbit: rounded prescaler 0 forced to 1, n=8 best
    run(1'b0, 1'b0, 32'd0, 32'd8_000_000, 32'd4_000_000, w, lat, bs);
    chk("R3 prescaler floor 1 n=8", w, 32'h004A_0001);
    // 9 MHz / 1 Mbit: n=9, ts1=5 odd -> prop 3, ps1 2
    run(1'b0, 1'b0, 32'd0, 32'd9_000_000, 32'd1_000_000, w, lat, bs);
    chk("R5 R6 n=9 odd split", w, 32'h004A_0002);
  endtask

  task automatic t_busy_start();
    logic [31:0] w; int lat;
    @(negedge clk);
    bypass = 1'b0; src_bus = 1'b1; bus_hz = 32'd60_000_000; rate = 32'd250_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    bypass = 1'b1; rate = 32'h1234_5678; start = 1'b1;
    @(negedge clk);
    start = 1'b0; bypass = 1'b0; rate = 32'd250_000;
    chk("R9 stray start no done", 32'(done), 32'd0);
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    w = word;
    chk("R9 search result kept", w, ref_word(60_000_000, 250_000, 1'b1));
    repeat (10) @(negedge clk);
    chk("R8 word held after done", word, w);
    chk("R8 single done", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_bypass();
    t_src();
    t_exact();
    t_tie();
    t_clamp();
    t_zero_presc();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule